// File: doc/BRIEF.md
# Buffered Byte-Wide SPI Master

This block is a serial-peripheral-interface master that moves one byte at a time. Software writes a byte into a one-byte transmit holding buffer. The engine copies it into a shift register and clocks it out on `sclk`/`mosi`. At the same time it collects the incoming bits from `miso` into a one-byte receive buffer. A single eight-bit control/status register selects the clock polarity, the clock phase and the bit order, and turns the engine on. The same register reports four sticky flags.

The bit clock is paced by `bit_en`. Each cycle in which `bit_en` is high moves `sclk` by one half period. A byte therefore takes sixteen enable pulses. If the transmit buffer already holds the next byte when a byte ends, the next byte starts on the very next half period. The interrupt output follows either the transmit-buffer-empty condition or the byte-complete flag, as chosen by `irq_on_done`.

Register bus:
- `bus_sel` with `bus_wr` high writes a register.
- `bus_sel` with `bus_wr` low reads a register. `bus_rdata` is combinational.
- Reads take effect (clear flags) at the next clock edge.

Addresses: 0 is the control register, 1 is the transmit buffer (write only) and 2 is the receive buffer (read only).

Top module: `spi_byte_master`

## Requirements
- R1: Control register bits, from bit 7 down to bit 0, are: lsb-first, overrun, complete, tx-empty, rx-full, phase, polarity, enable. Software can write only bits 7, 2, 1 and 0. After reset the register reads 0x10 and `sclk` is low.
- R2: While enable is 0, tx-empty reads 1, writes to the transmit buffer are dropped, and `sclk` rests at the polarity level without toggling.
- R3: A write to the transmit buffer clears tx-empty. Tx-empty returns to 1 when the byte moves into the shift register, which happens on the next clock if the engine is idle.
- R4: With `irq_on_done` low, `irq` stays low after enable until a byte has been written and moved into the shift register. After that, `irq` equals tx-empty. Disabling the block re-arms this gate.
- R5: With lsb-first 1, `mosi` carries bit 0 first. With lsb-first 0, it carries bit 7 first.
- R6: `sclk` idles at the polarity bit. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. Each `bit_en` pulse makes exactly one `sclk` edge, and `sclk` holds still between pulses.
- R7: After the sixteenth edge of a byte, the received byte (first bit in the same order as transmitted) is loaded into the receive buffer and rx-full sets. A read of address 2 returns the byte and clears rx-full.
- R8: Complete sets after the sixteenth edge of a byte. Any read of the control register clears it.
- R9: Overrun sets when a byte is loaded into the receive buffer while rx-full is still 1. Any read of the control register clears it.
- R10: If the transmit buffer is full when a byte ends, the next byte begins with no idle half period. Two such bytes produce 32 edges spaced evenly by the `bit_en` period.
- R11: With `irq_on_done` high, `irq` equals the complete flag while enabled, so a control register read drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Half-period step enable for `sclk` |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 transmit buffer, 2 receive buffer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_on_done | input | 1 | Interrupt source: 0 tx-empty, 1 complete |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the seam between two back-to-back bytes. There, the last sample of one byte, the reload of the shift register and the receive-buffer load all fall on one clock edge. The bench reaches it by writing the second byte while the first is still shifting, with the clock slowed so that the write lands in time. It then checks the edge count and spacing across both bytes, the overrun caused by the unread first byte, and the complete-driven interrupt. Looping `miso` back from `mosi`, inverted in some runs, lets every mode and bit order be checked for both directions of data at once.

// File: rtl/spi_byte_master.sv
module spi_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_on_done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TX   = 2'd1;
  localparam logic [1:0] A_RX   = 2'd2;
  localparam int NBITS  = 8;
  localparam int HALVES = 2 * NBITS;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

  logic lsb_first, cpha, cpol, en;
  logic done_f, ovr_f, rxf_f, tx_full, armed, busy, lvl;
  logic [HW-1:0] half;
  logic [NBITS-1:0] tx_buf, tx_sh, rx_sh, rx_buf, rx_nxt;

  logic rd, wr, rd_ctrl, rd_rx, wr_ctrl, wr_tx;
  logic step, leading, last, smp, shf, load, rx_load;

  assign rd      = bus_sel & ~bus_wr;
  assign wr      = bus_sel & bus_wr;
  assign rd_ctrl = rd && bus_addr == A_CTRL;
  assign rd_rx   = rd && bus_addr == A_RX;
  assign wr_ctrl = wr && bus_addr == A_CTRL;
  assign wr_tx   = wr && bus_addr == A_TX && en;

  assign step    = busy & bit_en & en;
  assign leading = ~lvl;
  assign last    = step && half == LAST_HALF;
  assign smp     = step && (leading ^ cpha);
  assign shf     = step && (cpha ? (leading && half != '0) : (!leading && !last));
  assign load    = en && tx_full && (!busy || last);
  assign rx_load = last;

  always_comb begin
    rx_nxt = rx_sh;
    if (smp) rx_nxt = lsb_first ? {miso, rx_sh[NBITS-1:1]} : {rx_sh[NBITS-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lsb_first, cpha, cpol, en} <= '0;
      busy    <= 1'b0;
      lvl     <= 1'b0;
      half    <= '0;
      tx_full <= 1'b0;
      armed   <= 1'b0;
      tx_buf  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      if (wr_ctrl) {lsb_first, cpha, cpol, en} <= {bus_wdata[7], bus_wdata[2], bus_wdata[1], bus_wdata[0]};
      if (wr_tx) tx_buf <= bus_wdata;
      if (!en) begin
        busy    <= 1'b0;
        lvl     <= 1'b0;
        half    <= '0;
        tx_full <= 1'b0;
        armed   <= 1'b0;
      end else begin
        if (step) begin
          lvl  <= ~lvl;
          half <= half + 1'b1;
        end
        rx_sh <= rx_nxt;
        if (load) begin
          tx_sh <= tx_buf;
          busy  <= 1'b1;
          armed <= 1'b1;
          half  <= '0;
        end else begin
          if (shf) tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
          if (last) busy <= 1'b0;
        end
        tx_full <= wr_tx | (tx_full & ~load);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0;
      ovr_f  <= 1'b0;
      rxf_f  <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (last) done_f <= 1'b1;
      else if (rd_ctrl) done_f <= 1'b0;

      if (rx_load && rxf_f && !rd_rx) ovr_f <= 1'b1;
      else if (rd_ctrl) ovr_f <= 1'b0;

      if (rx_load) begin
        rx_buf <= rx_nxt;
        rxf_f  <= 1'b1;
      end else if (rd_rx) begin
        rxf_f <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {lsb_first, ovr_f, done_f, ~tx_full, rxf_f, cpha, cpol, en};
      A_RX:    bus_rdata = rx_buf;
      default: bus_rdata = '0;
    endcase
  end

  assign sclk = cpol ^ lvl;
  assign mosi = lsb_first ? tx_sh[0] : tx_sh[NBITS-1];
  assign irq  = en & (irq_on_done ? done_f : (armed & ~tx_full));
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic en,
  input logic busy,
  input logic tx_full,
  input logic done_f,
  input logic ovr_f,
  input logic rxf_f,
  input logic rx_load,
  input logic rd_rx,
  input logic wr_ctrl,
  input logic sclk,
  input logic cpol
);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk == cpol);
  // R6
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !bit_en && !wr_ctrl) |=> $stable(sclk));
  // R2
  off_state_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!busy && !tx_full));
  // R8
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_f) |-> $past(busy));
  // R9
  ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_f) |-> $past(rxf_f));
  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_rx && !rx_load) |=> !rxf_f);
endmodule

bind spi_byte_master spi_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .en(en), .busy(busy), .tx_full(tx_full),
  .done_f(done_f), .ovr_f(ovr_f), .rxf_f(rxf_f), .rx_load(rx_load), .rd_rx(rd_rx),
  .wr_ctrl(wr_ctrl), .sclk(sclk), .cpol(cpol)
);

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
  localparam int P = 4;
  logic clk = 0, rst_n = 0, bit_en = 0;
  logic bus_sel = 0, bus_wr = 0, irq_on_done = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi, miso, irq;
  logic inv = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  bit mon_on = 0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb = 0;
  logic prev_sclk = 0, prev_mosi = 0;
  logic [7:0] mon_byte = 0;
  int mon_bits = 0, edge_cnt = 0, first_edge = -1, last_edge = -1, cyc = 0;

  always #5 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_on_done(irq_on_done), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  int div = 0;
  always @(negedge clk) begin
    cyc++;
    div = (div + 1) % P;
    bit_en <= (div == 0);
  end

  always @(negedge clk) begin
    if (mon_on && sclk !== prev_sclk) begin
      edge_cnt++;
      if (first_edge < 0) first_edge = cyc;
      last_edge = cyc;
      if ((sclk != cfg_cpol) ^ cfg_cpha) begin
        mon_byte = cfg_lsb ? {prev_mosi, mon_byte[7:1]} : {mon_byte[6:0], prev_mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          mon_bits = 0;
          if (exp_q.size() == 0) chk("R5 unexpected byte", mon_byte, 8'hxx);
          else chk("R5 mosi byte", mon_byte, exp_q.pop_front());
        end
      end
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_w(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_r(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    bus_w(2'd1, b);
  endtask

  task automatic restart(input logic lsb, input logic cpha, input logic cpol, output logic [7:0] cfg);
    logic [7:0] d;
    mon_on = 0;
    bus_w(2'd0, 8'h00);
    bus_r(2'd0, d);
    bus_r(2'd2, d);
    cfg = {lsb, 3'b000, 1'b0, cpha, cpol, 1'b1};
    cfg_lsb = lsb; cfg_cpha = cpha; cfg_cpol = cpol;
    bus_w(2'd0, cfg);
    wait_cyc(2);
    mon_bits = 0; edge_cnt = 0; first_edge = -1; last_edge = -1;
    mon_on = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, cfg, b, b2;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    bus_r(2'd0, d);
    chk("R1 reset ctrl", d, 8'h10);
    chk("R1 reset sclk", {7'd0, sclk}, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    mon_on = 1; edge_cnt = 0;
    bus_w(2'd1, 8'hA5);
    wait_cyc(40);
    bus_r(2'd0, d);
    chk("R2 disabled tx write dropped", d, 8'h10);
    chk("R2 no sclk edges while off", edge_cnt[7:0], 8'd0);
    mon_on = 0;

    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 2; l++) begin
        inv = l[0];
        restart(l[0], m[1], m[0], cfg);
        bus_r(2'd0, d);
        chk("R2 tx-empty after enable", d, cfg | 8'h10);
        chk("R4 irq low after enable", {7'd0, irq}, 8'h00);
        chk("R6 idle level", {7'd0, sclk}, {7'd0, m[0]});
        b = 8'hB1 + 8'(m) * 8'h1D + 8'(l) * 8'h62;
        send(b);
        wait_cyc(2);
        chk("R4 irq after move to shifter", {7'd0, irq}, 8'h01);
        wait_cyc(16 * P + 12);
        bus_r(2'd0, d);
        chk("R8 complete and rx-full set", d, cfg | 8'h38);
        bus_r(2'd0, d);
        chk("R8 complete cleared by read", d, cfg | 8'h18);
        bus_r(2'd2, d);
        chk("R7 rx byte", d, b ^ {8{inv}});
        bus_r(2'd0, d);
        chk("R7 rx-full cleared", d, cfg | 8'h10);
        chk("R6 edge count", edge_cnt[7:0], 8'd16);
        chk("R6 edge spacing", 8'(last_edge - first_edge), 8'(15 * P));
        chk("R6 idle after byte", {7'd0, sclk}, {7'd0, m[0]});
      end
    end

    inv = 0;
    restart(1'b0, 1'b0, 1'b0, cfg);
    send(8'h5A);
    wait_cyc(16 * P + 12);
    send(8'hC3);
    wait_cyc(16 * P + 12);
    bus_r(2'd0, d);
    chk("R9 overrun set", d, cfg | 8'h78);
    bus_r(2'd0, d);
    chk("R9 overrun cleared by read", d, cfg | 8'h18);
    bus_r(2'd2, d);
    chk("R9 rx holds newest byte", d, 8'hC3);

    inv = 1;
    irq_on_done = 1;
    restart(1'b1, 1'b1, 1'b1, cfg);
    b = 8'h96; b2 = 8'h2E;
    send(b);
    wait_cyc(2);
    send(b2);
    bus_r(2'd0, d);
    chk("R3 tx-empty cleared while busy", d, cfg);
    chk("R11 irq low before complete", {7'd0, irq}, 8'h00);
    wait_cyc(32 * P + 12);
    chk("R10 edge count back-to-back", edge_cnt[7:0], 8'd32);
    chk("R10 no idle gap", 8'(last_edge - first_edge), 8'(31 * P));
    chk("R11 irq on complete", {7'd0, irq}, 8'h01);
    bus_r(2'd0, d);
    chk("R9 overrun after back-to-back", d, cfg | 8'h78);
    chk("R11 irq cleared by ctrl read", {7'd0, irq}, 8'h00);
    bus_r(2'd2, d);
    chk("R7 rx second byte", d, b2 ^ 8'hFF);
    chk("R5 all bytes seen", 8'(exp_q.size()), 8'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule